// File: doc/BRIEF.md
# Reset Qualifier and Boot Sequencer

This block sits between a board-level, asynchronous, active-low reset input and a processor core. It brings the input into the clock domain, measures how long it stays low in units of state times (a fixed number of clock cycles), and takes the core into reset only when the low level has lasted long enough. Short glitches never disturb a running core.

When the input returns high, the block realigns its state-time divider and the clock output derived from it. It then runs a counted boot sequence while the core is still held. In the first state time the sequence asks the core to clear its status word. It then reads two configuration words from fixed addresses over a request/valid read port and latches them into configuration registers. At the end it releases the core and presents the fixed first fetch address with a one-cycle valid strobe. The reset input reads high when nothing drives it, so a board that leaves the pin floating still boots after power-on.

Top module: `rbs_boot_seq`

## Requirements
- R1: While `por_n` is low, the synchronizer reads the reset input as high (pull-up), `core_rst_n`, `rd_req` and `start_vld` are 0, and with the input left high the block boots once `por_n` rises.
- R2: If the synchronized input stays low for fewer than `MIN_LOW_ST` state times, a running core is not reset, and the width count restarts from zero whenever the input is seen high.
- R3: If the synchronized input stays low for `MIN_LOW_ST` state times, `core_rst_n` goes low and stays low while the input stays low.
- R4: In the cycle the held state sees the input high, the state-time divider restarts, so `clkout` is 1 for the first `ST_CYCLES/2` cycles after that edge and 0 for the rest of the state time.
- R5: `psw_clr` is 1 during the first state time of the boot sequence and only while `core_rst_n` is 0.
- R6: The first configuration read uses address `CFG_ADDR0` (default 16'h2018) and the second uses `CFG_ADDR1` (default 16'h201A). `rd_req` and `rd_addr` stay unchanged until `rd_valid` is seen, unless the sequence aborts.
- R7: `rd_data` seen with `rd_valid` during the first read goes to `cfg0`, and during the second read to `cfg1`.
- R8: With `rd_valid` returned in the cycle after `rd_req` rises, `core_rst_n` rises exactly `SEQ_ST` state times after the divider restart. Slower reads stall the sequence.
- R9: In the cycle `core_rst_n` rises, `start_vld` is 1 for exactly one cycle, with `start_addr` = `START_ADDR` (default 16'h2080).
- R10: A low level on the synchronized input at any point in the boot sequence aborts it at once, with no `start_vld`. The block then waits for the input to return high and starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_n | input | 1 | Asynchronous board reset input, active low |
| core_rst_n | output | 1 | Reset to the core, active low |
| clkout | output | 1 | State-time clock output, realigned on release |
| psw_clr | output | 1 | Request to clear the core status word |
| rd_req | output | 1 | Configuration read request |
| rd_addr | output | ADDR_W | Configuration read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| cfg0 | output | DATA_W | First configuration register |
| cfg1 | output | DATA_W | Second configuration register |
| start_vld | output | 1 | One-cycle strobe for the first fetch address |
| start_addr | output | ADDR_W | First fetch address |

## Verification
Several rules are checked on every cycle by properties. The width count clears when the input is seen high, and a qualified reset persists while the input stays low. A restart leaves `clkout` high. `psw_clr` appears only under reset, and a pending read holds its request and address. An abort always returns to the held state, and every release carries a one-cycle start strobe. Other behaviours can only be shown by the bench scenarios: the exact cycle of release, the order and content of the configuration words, whether a pulse just below or just above the threshold resets the core, and that an aborted sequence produces no start strobe.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic [2:0] {
      BS_HOLD,
      BS_SEQ,
      BS_RD0,
      BS_RD1,
      BS_RUN
   } boot_st_t;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad
      $error("rbs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   // reset value 1 models the pull-up on the input
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rbs_tick.sv
module rbs_tick #(
   parameter int ST_CYCLES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic realign,
   output logic tick,
   output logic clkout
);
   localparam int DW   = (ST_CYCLES > 1) ? $clog2(ST_CYCLES) : 1;
   localparam int HALF = ST_CYCLES / 2;

   if (ST_CYCLES < 2 || (ST_CYCLES % 2) != 0) begin : g_bad
      $error("rbs_tick: ST_CYCLES must be even and at least 2");
   end

   logic [DW-1:0] div_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                div_cnt <= '0;
      else if (realign)                          div_cnt <= '0;
      else if (div_cnt == DW'(ST_CYCLES - 1))    div_cnt <= '0;
      else                                       div_cnt <= div_cnt + 1'b1;
   end

   assign tick   = (div_cnt == DW'(ST_CYCLES - 1));
   assign clkout = (div_cnt < DW'(HALF));

   // R4: a restart leaves the clock output in its high phase
   a_r4_realign_high: assert property (@(posedge clk) disable iff (!por_n)
      realign |=> clkout);
endmodule

// File: rtl/rbs_qual.sv
module rbs_qual #(
   parameter int MIN_LOW_ST = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_s,
   input  logic tick,
   output logic qualified
);
   localparam int CW = $clog2(MIN_LOW_ST + 1);

   if (MIN_LOW_ST < 1) begin : g_bad
      $error("rbs_qual: MIN_LOW_ST must be at least 1");
   end

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    low_cnt <= '0;
      else if (pin_s)                low_cnt <= '0;
      else if (tick && !qualified)   low_cnt <= low_cnt + 1'b1;
   end

   assign qualified = (low_cnt == CW'(MIN_LOW_ST));

   // R2: a high input restarts the width measurement
   a_r2_restart_on_high: assert property (@(posedge clk) disable iff (!por_n)
      pin_s |=> !qualified);
   // R3: once qualified, a low input keeps the reset recognized
   a_r3_qual_persists: assert property (@(posedge clk) disable iff (!por_n)
      (qualified && !pin_s) |=> qualified);
endmodule

// File: rtl/rbs_seq.sv
module rbs_seq
   import rbs_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 16,
   parameter int          SEQ_ST     = 10,
   parameter logic [15:0] CFG_ADDR0  = 16'h2018,
   parameter logic [15:0] CFG_ADDR1  = 16'h201A,
   parameter logic [15:0] START_ADDR = 16'h2080
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pin_s,
   input  logic              tick,
   input  logic              qualified,
   output logic              realign,
   output logic              core_rst_n,
   output logic              psw_clr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] cfg0,
   output logic [DATA_W-1:0] cfg1,
   output logic              start_vld,
   output logic [ADDR_W-1:0] start_addr
);
   localparam int SW = $clog2(SEQ_ST);

   if (SEQ_ST < 5) begin : g_bad
      $error("rbs_seq: SEQ_ST must be at least 5");
   end

   boot_st_t      state;
   logic [SW-1:0] st_cnt;
   logic          in_boot;

   assign in_boot = (state == BS_SEQ) || (state == BS_RD0) || (state == BS_RD1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state     <= BS_HOLD;
         st_cnt    <= '0;
         cfg0      <= '0;
         cfg1      <= '0;
         start_vld <= 1'b0;
      end else begin
         start_vld <= 1'b0;
         if (in_boot && !pin_s) begin
            state <= BS_HOLD;
         end else begin
            case (state)
               BS_HOLD: if (pin_s) begin
                  state  <= BS_SEQ;
                  st_cnt <= '0;
               end
               BS_SEQ: if (tick) begin
                  if (st_cnt == SW'(1)) begin
                     state  <= BS_RD0;
                     st_cnt <= SW'(2);
                  end else if (st_cnt == SW'(3)) begin
                     state  <= BS_RD1;
                     st_cnt <= SW'(4);
                  end else if (st_cnt == SW'(SEQ_ST - 1)) begin
                     state     <= BS_RUN;
                     start_vld <= 1'b1;
                  end else begin
                     st_cnt <= st_cnt + 1'b1;
                  end
               end
               BS_RD0: if (rd_valid) begin
                  cfg0  <= rd_data;
                  state <= BS_SEQ;
               end
               BS_RD1: if (rd_valid) begin
                  cfg1  <= rd_data;
                  state <= BS_SEQ;
               end
               BS_RUN: if (qualified) state <= BS_HOLD;
               default: state <= BS_HOLD;
            endcase
         end
      end
   end

   assign realign    = (state == BS_HOLD) && pin_s;
   assign core_rst_n = (state == BS_RUN);
   assign psw_clr    = (state == BS_SEQ) && (st_cnt == '0);
   assign rd_req     = (state == BS_RD0) || (state == BS_RD1);
   assign rd_addr    = (state == BS_RD1) ? ADDR_W'(CFG_ADDR1) : ADDR_W'(CFG_ADDR0);
   assign start_addr = ADDR_W'(START_ADDR);

   // R5: status clear only while the core is held
   a_r5_psw_under_reset: assert property (@(posedge clk) disable iff (!por_n)
      psw_clr |-> !core_rst_n);
   // R6: a pending read keeps request and address
   a_r6_read_held: assert property (@(posedge clk) disable iff (!por_n)
      (rd_req && !rd_valid && pin_s) |=> (rd_req && $stable(rd_addr)));
   // R9: every release carries the start strobe
   a_r9_start_on_release: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_rst_n) |-> start_vld);
   // R9: the strobe lasts one cycle
   a_r9_start_single: assert property (@(posedge clk) disable iff (!por_n)
      start_vld |=> !start_vld);
   // R10: low input during the sequence aborts to the held state
   a_r10_abort: assert property (@(posedge clk) disable iff (!por_n)
      (in_boot && !pin_s) |=> (state == BS_HOLD && !start_vld));
endmodule

// File: rtl/rbs_boot_seq.sv
module rbs_boot_seq #(
   parameter int          ST_CYCLES   = 2,
   parameter int          MIN_LOW_ST  = 16,
   parameter int          SEQ_ST      = 10,
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 16,
   parameter logic [15:0] CFG_ADDR0   = 16'h2018,
   parameter logic [15:0] CFG_ADDR1   = 16'h201A,
   parameter logic [15:0] START_ADDR  = 16'h2080
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   output logic              core_rst_n,
   output logic              clkout,
   output logic              psw_clr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] cfg0,
   output logic [DATA_W-1:0] cfg1,
   output logic              start_vld,
   output logic [ADDR_W-1:0] start_addr
);
   logic pin_s, tick, qualified, realign;

   rbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .din(rst_pin_n), .dout(pin_s));

   rbs_tick #(.ST_CYCLES(ST_CYCLES)) u_tick (
      .clk(clk), .por_n(por_n), .realign(realign), .tick(tick), .clkout(clkout));

   rbs_qual #(.MIN_LOW_ST(MIN_LOW_ST)) u_qual (
      .clk(clk), .por_n(por_n), .pin_s(pin_s), .tick(tick), .qualified(qualified));

   rbs_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_ST(SEQ_ST),
      .CFG_ADDR0(CFG_ADDR0), .CFG_ADDR1(CFG_ADDR1), .START_ADDR(START_ADDR)
   ) u_seq (
      .clk(clk), .por_n(por_n), .pin_s(pin_s), .tick(tick), .qualified(qualified),
      .realign(realign), .core_rst_n(core_rst_n), .psw_clr(psw_clr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .cfg0(cfg0), .cfg1(cfg1), .start_vld(start_vld), .start_addr(start_addr));
endmodule

// File: tb/sim_rbs_boot_seq.sv
module sim_rbs_boot_seq;
   localparam int ST    = 2;
   localparam int MINST = 16;
   localparam int SEQ   = 10;
   localparam int SYNC  = 2;
   // release edge count: SYNC flops, one edge into the sequence, SEQ state times
   localparam int T_REL = SYNC + 1 + SEQ * ST;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        core_rst_n, clkout, psw_clr, rd_req, start_vld;
   logic [15:0] rd_addr, cfg0, cfg1, start_addr;
   logic        rd_valid = 1'b0;
   logic [15:0] rd_data = '0;

   int checks = 0, fails = 0, starts = 0;
   int mem_lat = 0;
   logic [15:0] word0 = '0, word1 = '0;
   logic [15:0] addr_log [$];
   logic [31:0] exp_q [$];

   always #5 clk = ~clk;

   rbs_boot_seq #(.ST_CYCLES(ST), .MIN_LOW_ST(MINST), .SEQ_ST(SEQ), .SYNC_STAGES(SYNC))
   u0 (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .core_rst_n(core_rst_n),
      .clkout(clkout), .psw_clr(psw_clr), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg0(cfg0), .cfg1(cfg1),
      .start_vld(start_vld), .start_addr(start_addr));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   // memory model: answers a request after mem_lat extra cycles
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rd_req) begin
            addr_log.push_back(rd_addr);
            for (int i = 0; i < mem_lat; i++) begin
               @(posedge clk); #1;
            end
            if (rd_req) begin
               rd_valid = 1'b1;
               rd_data  = (rd_addr == 16'h2018) ? word0 :
                          (rd_addr == 16'h201A) ? word1 : 16'hDEAD;
               @(posedge clk); #1;
               rd_valid = 1'b0;
            end
         end
      end
   end

   // scoreboard monitor: each start strobe pops one expected configuration
   initial begin
      forever begin
         @(posedge clk); #1;
         if (start_vld) begin
            starts++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected start", 1, 0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               check(cfg0 == e[31:16], "R7 cfg0", cfg0, e[31:16]);
               check(cfg1 == e[15:0], "R7 cfg1", cfg1, e[15:0]);
               check(start_addr == 16'h2080, "R9 start_addr", start_addr, 16'h2080);
               check(core_rst_n == 1'b1, "R9 strobe with release", core_rst_n, 1);
            end
         end
      end
   end

   // driver: arm memory and scoreboard for a boot
   task automatic arm(input int lat, input logic [15:0] w0, input logic [15:0] w1);
      mem_lat = lat;
      word0 = w0;
      word1 = w1;
      exp_q.push_back({w0, w1});
      addr_log.delete();
   endtask

   // release the input and count edges until the core runs
   task automatic release_pin(output int n, output bit ck_hi, output bit ck_lo,
                              output bit psw_seen);
      @(negedge clk);
      rst_pin_n = 1'b1;
      n = 0; ck_hi = 0; ck_lo = 0; psw_seen = 0;
      do begin
         @(posedge clk); #1;
         n++;
         if (n == SYNC + 1)        ck_hi = clkout;
         if (n == SYNC + 1 + ST/2) ck_lo = !clkout;
         if (psw_clr) psw_seen = 1;
      end while (!core_rst_n && n < 2000);
   endtask

   task automatic pin_low(input int n);
      @(negedge clk);
      rst_pin_n = 1'b0;
      cycles(n);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      int n;
      bit hi, lo, ps;
      // R1 reset state with the input undriven-high
      cycles(3);
      check(core_rst_n == 0, "R1 core held in por", core_rst_n, 0);
      check(rd_req == 0, "R1 no read in por", rd_req, 0);
      check(start_vld == 0, "R1 no start in por", start_vld, 0);
      arm(0, 16'hA55A, 16'h1234);
      @(negedge clk);
      por_n = 1'b1;
      n = 0;
      while (!core_rst_n && n < 500) begin
         @(posedge clk); #1; n++;
      end
      check(core_rst_n == 1, "R1 boots with pin high", core_rst_n, 1);
      check(addr_log.size() == 2 && addr_log[0] == 16'h2018 && addr_log[1] == 16'h201A,
            "R6 read order", addr_log.size() > 0 ? addr_log[0] : 0, 16'h2018);
      cycles(4);

      // R2 short pulse ignored
      pin_low((MINST - 1) * ST);
      rst_pin_n = 1'b1;
      cycles(2 * ST * MINST);
      check(core_rst_n == 1, "R2 short pulse ignored", core_rst_n, 1);
      // R2 restart: two sub-threshold lows split by a brief high
      pin_low(10 * ST);
      rst_pin_n = 1'b1;
      cycles(3);
      pin_low(10 * ST);
      rst_pin_n = 1'b1;
      cycles(2 * ST * MINST);
      check(core_rst_n == 1, "R2 count restarts on high", core_rst_n, 1);

      // R3 qualified reset
      pin_low((MINST + 2) * ST);
      check(core_rst_n == 0, "R3 core held after long low", core_rst_n, 0);
      cycles(20);
      check(core_rst_n == 0, "R3 still held while low", core_rst_n, 0);
      arm(0, 16'h0F0F, 16'hBEEF);
      release_pin(n, hi, lo, ps);
      check(n == T_REL, "R8 release cycle zero-wait", n, T_REL);
      check(hi, "R4 clkout high after restart", hi, 1);
      check(lo, "R4 clkout low in second half", lo, 1);
      check(ps, "R5 status clear seen", ps, 1);
      check(addr_log.size() == 2 && addr_log[1] == 16'h201A, "R6 second address",
            addr_log.size() > 1 ? addr_log[1] : 0, 16'h201A);
      cycles(4);

      // R8 stalled reads
      pin_low((MINST + 2) * ST);
      arm(3, 16'h7E57, 16'hC0DE);
      release_pin(n, hi, lo, ps);
      check(n > T_REL, "R8 slow reads stall", n, T_REL + 1);
      check(core_rst_n == 1, "R8 boot completes", core_rst_n, 1);
      cycles(4);

      // R10 abort in the middle of the sequence
      pin_low((MINST + 2) * ST);
      @(negedge clk);
      rst_pin_n = 1'b1;
      cycles(SYNC + 6);
      n = starts;
      pin_low(4);
      rst_pin_n = 1'b1;
      check(core_rst_n == 0, "R10 abort keeps core held", core_rst_n, 0);
      pin_low(6);
      arm(0, 16'h1111, 16'h2222);
      release_pin(n, hi, lo, ps);
      check(n == T_REL, "R10 fresh sequence length", n, T_REL);
      cycles(4);
      check(starts == 4, "R10 one start per completed boot", starts, 4);
      check(exp_q.size() == 0, "R7 all boots scored", exp_q.size(), 0);
      summary();
   end
endmodule